// File: doc/BRIEF.md
# DMA Request Bandwidth Limiter and Work-Unit Monitor

This block sits next to the request port of a single DMA channel. One half throttles the channel's raw bus request so that two granted requests are never closer together than a programmed number of system clock cycles. A limit of zero leaves the channel unrestricted, and the all-ones limit blocks it completely. Throttling only delays requests and never loses them: a raw request that is held high is passed on once the spacing has elapsed.

The other half is a watchdog for work units. Software programs a cycle budget. The budget is copied into a running count whenever the configuration is written, a work unit ends, or an auto-buffer wraps. The count then falls by one on every cycle a work unit is active. If it reaches zero first, a sticky error flag is raised with error code 6. The transfer keeps running, and the count stays at zero until the next reload. A budget of zero turns the monitor off.

Top module: `dma_bw_guard`

## Requirements
- R1: `req_out` is high only while `req_in` is high. When the limit is not all-ones, a raw request that is held high is granted once the spacing has elapsed. A cycle in which `req_out` is high counts as one granted request.
- R2: While the stored limit is 0 (or 1), `req_out` follows `req_in` in the same cycle, on every cycle.
- R3: When the stored limit N is between 2 and 0xFFFE, two granted requests are at least N cycles apart. A continuously held request is granted exactly every N cycles. The first request after the limit is written is granted at once, because a limit write clears the spacing counter.
- R4: While the stored limit is all ones (0xFFFF at the default width), `req_out` stays low whatever `req_in` does.
- R5: A pulse on `cfg_wr`, `wu_end` or `buf_wrap` loads the stored budget into `mon_cur`, and the new value is visible after that clock edge. A reload takes priority over a decrement.
- R6: On each cycle with `wu_active` high, a nonzero budget, a nonzero count and no reload, `mon_cur` falls by one.
- R7: The decrement that takes `mon_cur` from 1 to 0 sets `err_flag` and makes `err_code` equal 6 on the same edge. A work unit that ends while the count is still above zero raises no error.
- R8: Once `mon_cur` is 0 it stays 0 until a reload event occurs.
- R9: With a stored budget of 0, `mon_cur` does not change except through reloads (which load 0), and no error is raised.
- R10: `err_flag` and `err_code` hold until an `err_clr` pulse sets them back to 0 and 0. If an expiry happens in the same cycle as `err_clr`, the expiry wins.
- R11: A monitor error leaves request gating unchanged, so requests are still granted after an expiry.
- R12: After reset the limit, the spacing counter, the budget, `mon_cur`, `err_flag` and `err_code` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lim_wr | input | 1 | Write strobe for the spacing limit |
| lim_wdata | input | LIM_W | New spacing limit in cycles |
| mon_wr | input | 1 | Write strobe for the monitor budget |
| mon_wdata | input | MON_W | New monitor budget in cycles |
| cfg_wr | input | 1 | Channel configuration write, reloads the monitor |
| req_in | input | 1 | Raw request from the channel |
| wu_active | input | 1 | A work unit is in progress |
| wu_end | input | 1 | Work unit finished, reloads the monitor |
| buf_wrap | input | 1 | Auto-buffer wrapped, reloads the monitor |
| err_clr | input | 1 | Write-one-to-clear of the error flag and code |
| req_out | output | 1 | Throttled request to the bus |
| mon_cur | output | MON_W | Current monitor count |
| err_flag | output | 1 | Sticky error-interrupt flag |
| err_code | output | 4 | Error code, 6 on a monitor expiry |

## Verification
The limiter is driven with a continuously held request, which separates correct spacing from a one-cycle slip in the counter. It is also driven with a request that drops and then comes back while the counter is still running, which shows that a held request is delayed rather than discarded. Limits of zero and of all ones show the two special encodings. Switching from all ones back to zero shows that a request held through the blocked period is not lost. The monitor is run until it expires, paused partway, reloaded by each of its three events, and finished just before expiry. Together these separate a wrong decrement condition, a missing reload source, an error raised one cycle late or early, and a count that wraps below zero. A zero budget and an expiry that lands in the same cycle as a clear cover the disabling and priority rules.

// File: rtl/dma_bw_pkg.sv
// Shared constants for the DMA bandwidth guard.
// Assumes a 4-bit error code field owned by this block.
package dma_bw_pkg;
    localparam int ERR_CODE_W = 4;
    localparam logic [ERR_CODE_W-1:0] ERR_NONE       = 4'h0;
    localparam logic [ERR_CODE_W-1:0] ERR_BW_TIMEOUT = 4'h6;
endpackage

// File: rtl/bw_req_limiter.sv
// Request spacing limiter: passes a raw request only once the programmed
// number of cycles has elapsed since the last grant. Limit 0 means free
// running; the all-ones limit blocks every request. Assumes the raw request
// is held until granted.
module bw_req_limiter #(
    parameter int LIM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lim_wr,
    input  logic [LIM_W-1:0] lim_wdata,
    input  logic             req_in,
    output logic             req_out,
    output logic [LIM_W-1:0] lim_val
);
    localparam logic [LIM_W-1:0] LIM_STOP = '1;
    localparam logic [LIM_W-1:0] ONE      = LIM_W'(1);

    logic [LIM_W-1:0] lim_q;
    logic [LIM_W-1:0] gap_q;
    logic             open_w;

    // Grant is possible when the gap counter is empty and the limit is not the stop code.
    always_comb begin
        open_w  = (gap_q == '0) && (lim_q != LIM_STOP);
        req_out = req_in && open_w;
    end

    // Hold the limit and count down the gap after each grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim_q <= '0;
            gap_q <= '0;
        end else if (lim_wr) begin
            lim_q <= lim_wdata;
            gap_q <= '0;
        end else if (req_out) begin
            gap_q <= (lim_q > ONE) ? (lim_q - ONE) : '0;
        end else if (gap_q != '0) begin
            gap_q <= gap_q - ONE;
        end
    end

    assign lim_val = lim_q;
endmodule

// File: rtl/bw_unit_monitor.sv
// Work-unit budget monitor: reloads a cycle budget on any of three events,
// counts down while a work unit is active, and pulses expire when the count
// reaches zero by decrement. Budget 0 disables counting. Assumes reload
// events are single-cycle strobes.
module bw_unit_monitor #(
    parameter int MON_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mon_wr,
    input  logic [MON_W-1:0] mon_wdata,
    input  logic             cfg_wr,
    input  logic             wu_end,
    input  logic             buf_wrap,
    input  logic             wu_active,
    output logic [MON_W-1:0] mon_cur,
    output logic [MON_W-1:0] budget,
    output logic             expire
);
    localparam logic [MON_W-1:0] ONE = MON_W'(1);

    logic [MON_W-1:0] budget_q;
    logic [MON_W-1:0] cur_q;
    logic             reload_w;
    logic             step_w;

    // Decode reload and countdown conditions.
    always_comb begin
        reload_w = cfg_wr || wu_end || buf_wrap;
        step_w   = wu_active && (budget_q != '0) && (cur_q != '0) && !reload_w;
        expire   = step_w && (cur_q == ONE);
    end

    // Store the programmed budget.
    always_ff @(posedge clk) begin
        if (!rst_n)       budget_q <= '0;
        else if (mon_wr)  budget_q <= mon_wdata;
    end

    // Reload or count down the current value, saturating at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)        cur_q <= '0;
        else if (reload_w) cur_q <= budget_q;
        else if (step_w)   cur_q <= cur_q - ONE;
    end

    assign mon_cur = cur_q;
    assign budget  = budget_q;
endmodule

// File: rtl/bw_err_latch.sv
// Sticky error status: sets the flag and timeout code on expiry, clears
// both on a write-one-to-clear strobe. Setting wins over clearing.
module bw_err_latch
    import dma_bw_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  expire,
    input  logic                  err_clr,
    output logic                  err_flag,
    output logic [ERR_CODE_W-1:0] err_code
);
    // Latch error on expiry, drop it on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_flag <= 1'b0;
            err_code <= ERR_NONE;
        end else if (expire) begin
            err_flag <= 1'b1;
            err_code <= ERR_BW_TIMEOUT;
        end else if (err_clr) begin
            err_flag <= 1'b0;
            err_code <= ERR_NONE;
        end
    end
endmodule

// File: rtl/dma_bw_guard.sv
// Per-channel DMA bandwidth guard: request spacing limiter plus work-unit
// budget monitor with sticky error status. The monitor never gates requests.
module dma_bw_guard
    import dma_bw_pkg::*;
#(
    parameter int LIM_W = 16,
    parameter int MON_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  lim_wr,
    input  logic [LIM_W-1:0]      lim_wdata,
    input  logic                  mon_wr,
    input  logic [MON_W-1:0]      mon_wdata,
    input  logic                  cfg_wr,
    input  logic                  req_in,
    input  logic                  wu_active,
    input  logic                  wu_end,
    input  logic                  buf_wrap,
    input  logic                  err_clr,
    output logic                  req_out,
    output logic [MON_W-1:0]      mon_cur,
    output logic                  err_flag,
    output logic [ERR_CODE_W-1:0] err_code
);
    logic [LIM_W-1:0] lim_val;
    logic [MON_W-1:0] mon_budget;
    logic             mon_expire;

    bw_req_limiter #(.LIM_W(LIM_W)) u_lim (
        .clk(clk), .rst_n(rst_n), .lim_wr(lim_wr), .lim_wdata(lim_wdata),
        .req_in(req_in), .req_out(req_out), .lim_val(lim_val)
    );

    bw_unit_monitor #(.MON_W(MON_W)) u_mon (
        .clk(clk), .rst_n(rst_n), .mon_wr(mon_wr), .mon_wdata(mon_wdata),
        .cfg_wr(cfg_wr), .wu_end(wu_end), .buf_wrap(buf_wrap),
        .wu_active(wu_active), .mon_cur(mon_cur), .budget(mon_budget),
        .expire(mon_expire)
    );

    bw_err_latch u_err (
        .clk(clk), .rst_n(rst_n), .expire(mon_expire), .err_clr(err_clr),
        .err_flag(err_flag), .err_code(err_code)
    );
endmodule

// File: rtl/dma_bw_guard_chk.sv
// Property checker for dma_bw_guard, attached with bind. Tracks cycles
// since the last grant with its own saturating counter.
module dma_bw_guard_chk #(
    parameter int LIM_W = 16,
    parameter int MON_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lim_wr,
    input logic             cfg_wr,
    input logic             wu_end,
    input logic             buf_wrap,
    input logic             err_clr,
    input logic             req_in,
    input logic             req_out,
    input logic [LIM_W-1:0] lim_val,
    input logic [MON_W-1:0] mon_budget,
    input logic [MON_W-1:0] mon_cur,
    input logic             err_flag,
    input logic [3:0]       err_code
);
    localparam logic [LIM_W:0] SINCE_MAX = '1;
    logic [LIM_W:0] since_q;
    logic           seen_q;
    logic           reload_w;

    assign reload_w = cfg_wr || wu_end || buf_wrap;

    // Count cycles since the latest grant under the current limit.
    always_ff @(posedge clk) begin
        if (!rst_n || lim_wr) begin
            since_q <= '0;
            seen_q  <= 1'b0;
        end else if (req_out) begin
            since_q <= (LIM_W+1)'(1);
            seen_q  <= 1'b1;
        end else if (since_q != SINCE_MAX) begin
            since_q <= since_q + (LIM_W+1)'(1);
        end
    end

    AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_out |-> req_in); // R1
    AST_FREE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_val == '0 && req_in) |-> req_out); // R2
    AST_MIN_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (req_out && seen_q && lim_val > LIM_W'(1)) |-> (since_q >= {1'b0, lim_val})); // R3
    AST_STOP_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_val == '1) |-> !req_out); // R4
    AST_RELOAD_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        reload_w |=> (mon_cur == $past(mon_budget))); // R5
    AST_ZERO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_cur == '0 && !reload_w) |=> (mon_cur == '0)); // R8
    AST_NO_ERR_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> ($past(mon_budget) != '0)); // R9
    AST_CODE_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> (err_code == 4'h6)); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clr) |=> err_flag); // R10
endmodule

bind dma_bw_guard dma_bw_guard_chk #(.LIM_W(LIM_W), .MON_W(MON_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .lim_wr(lim_wr), .cfg_wr(cfg_wr),
    .wu_end(wu_end), .buf_wrap(buf_wrap), .err_clr(err_clr),
    .req_in(req_in), .req_out(req_out), .lim_val(lim_val),
    .mon_budget(mon_budget), .mon_cur(mon_cur), .err_flag(err_flag),
    .err_code(err_code)
);

// File: tb/test_dma_bw_guard.sv
module test_dma_bw_guard;
    localparam int LIM_W = 16;
    localparam int MON_W = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             lim_wr = 1'b0;
    logic [LIM_W-1:0] lim_wdata = '0;
    logic             mon_wr = 1'b0;
    logic [MON_W-1:0] mon_wdata = '0;
    logic             cfg_wr = 1'b0;
    logic             req_in = 1'b0;
    logic             wu_active = 1'b0;
    logic             wu_end = 1'b0;
    logic             buf_wrap = 1'b0;
    logic             err_clr = 1'b0;
    logic             req_out;
    logic [MON_W-1:0] mon_cur;
    logic             err_flag;
    logic [3:0]       err_code;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    dma_bw_guard #(.LIM_W(LIM_W), .MON_W(MON_W)) i_dma_bw_guard (
        .clk(clk), .rst_n(rst_n), .lim_wr(lim_wr), .lim_wdata(lim_wdata),
        .mon_wr(mon_wr), .mon_wdata(mon_wdata), .cfg_wr(cfg_wr),
        .req_in(req_in), .wu_active(wu_active), .wu_end(wu_end),
        .buf_wrap(buf_wrap), .err_clr(err_clr), .req_out(req_out),
        .mon_cur(mon_cur), .err_flag(err_flag), .err_code(err_code)
    );

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_limit(input logic [LIM_W-1:0] v);
        lim_wr = 1'b1; lim_wdata = v;
        cyc();
        lim_wr = 1'b0;
    endtask

    task automatic set_budget_reload(input logic [MON_W-1:0] v);
        mon_wr = 1'b1; mon_wdata = v;
        cyc();
        mon_wr = 1'b0; cfg_wr = 1'b1;
        cyc();
        cfg_wr = 1'b0;
    endtask

    task automatic t_reset();
        #1;
        check("R12 req_out after reset", 32'(req_out), 0);
        check("R12 mon_cur after reset", mon_cur, 0);
        check("R12 err_flag after reset", 32'(err_flag), 0);
        check("R12 err_code after reset", 32'(err_code), 0);
        req_in = 1'b1;
        for (int i = 0; i < 5; i++) begin
            #1; check("R2 limit 0 passes every cycle", 32'(req_out), 1);
            cyc();
        end
        req_in = 1'b0;
    endtask

    task automatic t_spacing();
        set_limit(16'd4);
        req_in = 1'b1;
        for (int i = 0; i < 12; i++) begin
            #1; check("R3 held request every 4 cycles", 32'(req_out), 32'((i % 4) == 0));
            cyc();
        end
        req_in = 1'b0;
        set_limit(16'd3);
        req_in = 1'b1; #1; check("R3 first request after write", 32'(req_out), 1);
        cyc();
        req_in = 1'b0; cyc();
        req_in = 1'b1; #1; check("R1 returning request still waits", 32'(req_out), 0);
        cyc();
        #1; check("R1 held request granted after gap", 32'(req_out), 1);
        cyc();
        req_in = 1'b0;
    endtask

    task automatic t_stop();
        set_limit(16'hFFFF);
        req_in = 1'b1;
        for (int i = 0; i < 20; i++) begin
            #1; check("R4 stop code blocks", 32'(req_out), 0);
            cyc();
        end
        set_limit(16'd0);
        #1; check("R1 request held through stop not lost", 32'(req_out), 1);
        req_in = 1'b0;
    endtask

    task automatic t_monitor();
        set_budget_reload(32'd5);
        check("R5 cfg_wr reload", mon_cur, 5);
        wu_active = 1'b1; repeat (3) cyc();
        check("R6 counts while active", mon_cur, 2);
        wu_active = 1'b0; repeat (2) cyc();
        check("R6 holds while idle", mon_cur, 2);
        wu_end = 1'b1; cyc(); wu_end = 1'b0;
        check("R5 wu_end reload", mon_cur, 5);
        wu_active = 1'b1; repeat (4) cyc();
        check("R7 no error at count 1", 32'(err_flag), 0);
        cyc();
        check("R7 count reaches zero", mon_cur, 0);
        check("R7 error flag on expiry", 32'(err_flag), 1);
        check("R7 error code 6", 32'(err_code), 6);
        repeat (3) cyc();
        check("R8 zero holds", mon_cur, 0);
        check("R10 flag sticky", 32'(err_flag), 1);
        req_in = 1'b1; #1;
        check("R11 requests pass after error", 32'(req_out), 1);
        req_in = 1'b0; wu_active = 1'b0;
        err_clr = 1'b1; cyc(); err_clr = 1'b0;
        check("R10 clear drops flag", 32'(err_flag), 0);
        check("R10 clear drops code", 32'(err_code), 0);
        buf_wrap = 1'b1; cyc(); buf_wrap = 1'b0;
        check("R5 buf_wrap reload", mon_cur, 5);
    endtask

    task automatic t_finish_in_time();
        set_budget_reload(32'd5);
        wu_active = 1'b1; repeat (4) cyc();
        check("R6 count before finish", mon_cur, 1);
        wu_end = 1'b1; cyc(); wu_end = 1'b0; wu_active = 1'b0;
        check("R7 finishing in time raises no error", 32'(err_flag), 0);
        check("R5 reload wins over decrement", mon_cur, 5);
    endtask

    task automatic t_disabled();
        set_budget_reload(32'd0);
        wu_active = 1'b1; repeat (10) cyc(); wu_active = 1'b0;
        check("R9 budget 0 count stays 0", mon_cur, 0);
        check("R9 budget 0 no error", 32'(err_flag), 0);
    endtask

    task automatic t_set_beats_clear();
        set_budget_reload(32'd2);
        wu_active = 1'b1; cyc();
        check("R6 count 1", mon_cur, 1);
        err_clr = 1'b1; cyc(); err_clr = 1'b0; wu_active = 1'b0;
        check("R10 expiry wins over clear", 32'(err_flag), 1);
        err_clr = 1'b1; cyc(); err_clr = 1'b0;
        check("R10 later clear works", 32'(err_flag), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        t_reset();
        t_spacing();
        t_stop();
        t_monitor();
        t_finish_in_time();
        t_disabled();
        t_set_beats_clear();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule